// File: doc/BRIEF.md
# Accumulator Processor Core

A small multi-cycle processor built around a single data register, the accumulator. Every instruction is one 24-bit word from an external instruction memory. The top 8 bits select one of 21 operations and the low 16 bits give an immediate value, a data address or a jump target. Arithmetic reads one word from an internal data memory and combines it with the accumulator, which also receives the result. Pointers held in data memory give indirect loads and stores. Subroutine calls keep their return addresses in a hardware last-in-first-out stack.

The core reads a word from outside through a valid/ready handshake and writes words out through a one-cycle strobe. A stop instruction halts it, and so does a misuse of the return stack. A sticky error flag records a zero divisor and any misuse of the return stack. An ordinary instruction takes one fetch cycle and one execute cycle. An indirect access adds one cycle. A read waits for as long as the input is absent.

Top module: `acc_core`

## Requirements
- R1: After reset the core fetches from address 0 with the accumulator at 0 and the return stack empty. `halted`, `error`, `out_strobe` and `in_ready` are all low.
- R2: The instruction word carries the opcode in bits 23:16 and the operand in bits 15:0. Opcode 0 loads the operand into the accumulator. Opcode 1 adds the operand to the accumulator, modulo 2^16.
- R3: Opcodes 2 to 6 replace the accumulator with AC+M, AC-M, AC*M (low 16 bits), AC/M and AC%M. M is the data word at the operand address. Division is signed and truncates toward zero, and the remainder takes the sign of the dividend.
- R4: A divide or remainder by zero writes 0 to the accumulator and sets the sticky `error` flag. Execution continues.
- R5: Opcode 7 loads M[a] and opcode 8 stores to M[a]. Opcode 19 loads M[M[a]] and opcode 20 stores to M[M[a]]. Every data address, the pointer included, uses only its low DA_W bits (5 by default).
- R6: Opcode 9 jumps to the low PC_W bits of the operand. Opcodes 10, 11, 12 and 13 take that jump when the accumulator is zero, nonzero, at least 0, or below 0 as a signed number. Otherwise execution falls through.
- R7: Opcode 14 pushes the address of the next instruction and jumps. Opcode 15 pops the stack into the PC. Calls can be nested.
- R8: The return stack holds RS_DEPTH entries (8 by default). A push when it is full, or a pop when it is empty, sets `error` and halts the core.
- R9: Opcode 16 raises `in_ready` and stalls, with the PC held, until `in_valid` is high. On that edge `in_data` enters the accumulator.
- R10: Opcode 17 puts the accumulator on `out_data` and pulses `out_strobe` for exactly one cycle.
- R11: Opcode 18 sets `halted` and leaves `error` unchanged. Once halted, the PC holds and the core produces no strobe and no `in_ready` until reset.
- R12: Opcodes 21 to 255 change nothing except advancing the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PC_W | Instruction fetch address (the PC) |
| imem_data | input | 8+DATA_W | Instruction word at `imem_addr`, combinational |
| in_data | input | DATA_W | Input word |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Core is waiting in a read instruction |
| out_data | output | DATA_W | Last printed accumulator value |
| out_strobe | output | 1 | One-cycle pulse when `out_data` is new |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Sticky fault flag |

## Verification
The hardest condition to reach is a full return stack: it needs nine calls in a row with no return. The stimulus gets there with a three-word loop that increments the accumulator, prints it and calls itself. That puts the numbers 1 to 9 on the output and then halts with the error flag set. The arithmetic and branch sweep runs a read-driven program that loops over many operand pairs, with input stalls of varying length. The zero-divisor pair runs last, because the error flag it sets is sticky.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [7:0] {
        OP_LDI  = 8'd0,
        OP_ADDI = 8'd1,
        OP_ADD  = 8'd2,
        OP_SUB  = 8'd3,
        OP_MUL  = 8'd4,
        OP_DIV  = 8'd5,
        OP_REM  = 8'd6,
        OP_GET  = 8'd7,
        OP_PUT  = 8'd8,
        OP_GOTO = 8'd9,
        OP_BZ   = 8'd10,
        OP_BNZ  = 8'd11,
        OP_BGEZ = 8'd12,
        OP_BLTZ = 8'd13,
        OP_CALL = 8'd14,
        OP_RET  = 8'd15,
        OP_IN   = 8'd16,
        OP_OUT  = 8'd17,
        OP_STOP = 8'd18,
        OP_GETI = 8'd19,
        OP_PUTI = 8'd20
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_EXEC    = 3'd1,
        ST_IND     = 3'd2,
        ST_WAIT_IN = 3'd3,
        ST_HALT    = 3'd4
    } fsm_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_MUL,
        ALU_DIV,
        ALU_REM
    } alu_op_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res,
    output logic                div_zero
);

    logic signed [DATA_W-1:0] sa;
    logic signed [DATA_W-1:0] sb;
    logic                     b_zero;

    always_comb begin
        sa       = $signed(a);
        sb       = $signed(b);
        b_zero   = (b == '0);
        div_zero = 1'b0;
        res      = '0;
        case (op)
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_MUL: res = a * b;
            ALU_DIV: begin
                div_zero = b_zero;
                res      = b_zero ? '0 : DATA_W'(sa / sb);
            end
            ALU_REM: begin
                div_zero = b_zero;
                res      = b_zero ? '0 : DATA_W'(sa % sb);
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/acc_dmem.sv
module acc_dmem #(
    parameter int DATA_W = 16,
    parameter int DA_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DA_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DA_W-1:0]   raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << DA_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/acc_ret_stack.sv
module acc_ret_stack #(
    parameter int AW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_en,
    output logic [AW-1:0] top_addr,
    output logic          full,
    output logic          empty
);

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]   ent_q [DEPTH];
    logic [AW-1:0]   ent_d [DEPTH];
    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_d;
    logic [SP_W-1:0] sp_m1;

    always_comb begin
        full  = (sp_q == SP_W'(DEPTH));
        empty = (sp_q == '0);
        sp_m1 = sp_q - 1'b1;
        sp_d  = sp_q;
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (push_en && !full) begin
            ent_d[sp_q[IDX_W-1:0]] = push_addr;
            sp_d = sp_q + 1'b1;
        end else if (pop_en && !empty) begin
            sp_d = sp_m1;
        end
        top_addr = ent_q[sp_m1[IDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    // R8
    push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> !full)
        else $error("push issued on a full return stack");

    // R8
    pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> !empty)
        else $error("pop issued on an empty return stack");

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SP_W'(DEPTH))
        else $error("return stack pointer beyond depth");

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PC_W     = 8,
    parameter int DA_W     = 5,
    parameter int RS_DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [PC_W-1:0]         imem_addr,
    input  logic [OPC_W+DATA_W-1:0] imem_data,
    input  logic [DATA_W-1:0]       in_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    output logic [DATA_W-1:0]       out_data,
    output logic                    out_strobe,
    output logic                    halted,
    output logic                    error
);

    localparam int INSTR_W = OPC_W + DATA_W;

    typedef struct packed {
        fsm_e               fsm;
        logic [PC_W-1:0]    pc;
        logic [DATA_W-1:0]  ac;
        logic [INSTR_W-1:0] ir;
        logic [DA_W-1:0]    ptr;
        logic [DATA_W-1:0]  out;
        logic               stb;
        logic               halted;
        logic               err;
    } core_t;

    core_t r_q;
    core_t r_d;

    opcode_e           opc;
    logic [DATA_W-1:0] opnd;
    logic [DA_W-1:0]   daddr;
    logic [PC_W-1:0]   target;
    logic [PC_W-1:0]   pc_inc;
    logic              ac_zero;
    logic              ac_neg;

    logic              dm_we;
    logic [DA_W-1:0]   dm_waddr;
    logic [DATA_W-1:0] dm_wdata;
    logic [DA_W-1:0]   dm_raddr;
    logic [DATA_W-1:0] dm_rdata;

    logic              rs_push;
    logic              rs_pop;
    logic [PC_W-1:0]   rs_top;
    logic              rs_full;
    logic              rs_empty;

    alu_op_e           alu_sel;
    logic [DATA_W-1:0] alu_res;
    logic              alu_dz;
    logic              rdy;

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (alu_sel),
        .a        (r_q.ac),
        .b        (dm_rdata),
        .res      (alu_res),
        .div_zero (alu_dz)
    );

    acc_dmem #(.DATA_W(DATA_W), .DA_W(DA_W)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    acc_ret_stack #(.AW(PC_W), .DEPTH(RS_DEPTH)) u_rstack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (rs_push),
        .push_addr (pc_inc),
        .pop_en    (rs_pop),
        .top_addr  (rs_top),
        .full      (rs_full),
        .empty     (rs_empty)
    );

    // Instruction field split and ALU operation select
    always_comb begin
        opc     = opcode_e'(r_q.ir[INSTR_W-1 -: OPC_W]);
        opnd    = r_q.ir[DATA_W-1:0];
        daddr   = opnd[DA_W-1:0];
        target  = opnd[PC_W-1:0];
        pc_inc  = r_q.pc + 1'b1;
        ac_zero = (r_q.ac == '0);
        ac_neg  = r_q.ac[DATA_W-1];
        case (opc)
            OP_SUB:  alu_sel = ALU_SUB;
            OP_MUL:  alu_sel = ALU_MUL;
            OP_DIV:  alu_sel = ALU_DIV;
            OP_REM:  alu_sel = ALU_REM;
            default: alu_sel = ALU_ADD;
        endcase
    end

    // Next-state computation
    always_comb begin
        r_d      = r_q;
        r_d.stb  = 1'b0;
        dm_raddr = (r_q.fsm == ST_IND) ? r_q.ptr : daddr;
        dm_we    = 1'b0;
        dm_waddr = daddr;
        dm_wdata = r_q.ac;
        rs_push  = 1'b0;
        rs_pop   = 1'b0;
        rdy      = 1'b0;

        case (r_q.fsm)
            ST_FETCH: begin
                r_d.ir  = imem_data;
                r_d.fsm = ST_EXEC;
            end

            ST_EXEC: begin
                r_d.fsm = ST_FETCH;
                r_d.pc  = pc_inc;
                case (opc)
                    OP_LDI:  r_d.ac = opnd;
                    OP_ADDI: r_d.ac = r_q.ac + opnd;
                    OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_REM: begin
                        r_d.ac = alu_res;
                        if (alu_dz) r_d.err = 1'b1;
                    end
                    OP_GET:  r_d.ac = dm_rdata;
                    OP_PUT:  dm_we  = 1'b1;
                    OP_GETI, OP_PUTI: begin
                        r_d.ptr = dm_rdata[DA_W-1:0];
                        r_d.pc  = r_q.pc;
                        r_d.fsm = ST_IND;
                    end
                    OP_GOTO: r_d.pc = target;
                    OP_BZ:   if (ac_zero)  r_d.pc = target;
                    OP_BNZ:  if (!ac_zero) r_d.pc = target;
                    OP_BGEZ: if (!ac_neg)  r_d.pc = target;
                    OP_BLTZ: if (ac_neg)   r_d.pc = target;
                    OP_CALL: begin
                        if (rs_full) begin
                            r_d.err    = 1'b1;
                            r_d.halted = 1'b1;
                            r_d.pc     = r_q.pc;
                            r_d.fsm    = ST_HALT;
                        end else begin
                            rs_push = 1'b1;
                            r_d.pc  = target;
                        end
                    end
                    OP_RET: begin
                        if (rs_empty) begin
                            r_d.err    = 1'b1;
                            r_d.halted = 1'b1;
                            r_d.pc     = r_q.pc;
                            r_d.fsm    = ST_HALT;
                        end else begin
                            rs_pop = 1'b1;
                            r_d.pc = rs_top;
                        end
                    end
                    OP_IN: begin
                        r_d.pc  = r_q.pc;
                        r_d.fsm = ST_WAIT_IN;
                    end
                    OP_OUT: begin
                        r_d.out = r_q.ac;
                        r_d.stb = 1'b1;
                    end
                    OP_STOP: begin
                        r_d.pc     = r_q.pc;
                        r_d.halted = 1'b1;
                        r_d.fsm    = ST_HALT;
                    end
                    default: ;
                endcase
            end

            ST_IND: begin
                r_d.fsm = ST_FETCH;
                r_d.pc  = pc_inc;
                if (opc == OP_GETI) begin
                    r_d.ac = dm_rdata;
                end else begin
                    dm_we    = 1'b1;
                    dm_waddr = r_q.ptr;
                end
            end

            ST_WAIT_IN: begin
                rdy = 1'b1;
                if (in_valid) begin
                    r_d.ac  = in_data;
                    r_d.pc  = pc_inc;
                    r_d.fsm = ST_FETCH;
                end
            end

            ST_HALT: ;

            default: r_d.fsm = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign imem_addr  = r_q.pc;
    assign in_ready   = rdy;
    assign out_data   = r_q.out;
    assign out_strobe = r_q.stb;
    assign halted     = r_q.halted;
    assign error      = r_q.err;

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted)
        else $error("halt released without reset");

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!out_strobe && !in_ready))
        else $error("activity while halted");

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error)
        else $error("error flag cleared without reset");

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe)
        else $error("output strobe longer than one cycle");

    // R9
    wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (in_ready && $stable(imem_addr)))
        else $error("core moved on without input");

endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;

    localparam int DATA_W = 16;
    localparam int PC_W   = 8;
    localparam int DA_W   = 5;
    localparam int IW     = 8 + DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   imem_addr;
    logic [IW-1:0]     imem_data;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] out_data;
    logic              out_strobe;
    logic              halted;
    logic              error;

    always #2 clk = ~clk;

    logic [IW-1:0] prog [1 << PC_W];
    assign imem_data = prog[imem_addr];

    acc_core #(.DATA_W(DATA_W), .PC_W(PC_W), .DA_W(DA_W), .RS_DEPTH(8)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_data   (out_data),
        .out_strobe (out_strobe),
        .halted     (halted),
        .error      (error)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wp    = 0;
    bit done  = 1'b0;
    logic [15:0] exp_v [$];
    string       exp_tag [$];
    logic [15:0] ev;
    string       etag;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic emit(input int op, input logic [15:0] v);
        prog[wp] = {op[7:0], v};
        wp++;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < (1 << PC_W); i++) prog[i] = {8'd18, 16'd0};
        wp = 0;
    endtask

    task automatic want(input logic [15:0] v, input string tag);
        exp_v.push_back(v);
        exp_tag.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_strobe) begin
            if (exp_v.size() == 0) begin
                chk(1'b0, "R10 unexpected output", int'(out_data), 0);
            end else begin
                ev   = exp_v.pop_front();
                etag = exp_tag.pop_front();
                chk(out_data == ev, etag, int'(out_data), int'(ev));
            end
        end
    end

    // R1: reset state visible at the ports
    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(imem_addr == 0 && !halted && !error && !in_ready, "R1 reset state",
            {imem_addr, 3'b0, halted, error, in_ready}, 0);
    endtask

    task automatic wait_drain();
        int t = 0;
        while (exp_v.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_v.size() == 0, "R10 outputs missing", exp_v.size(), 0);
    endtask

    task automatic wait_halt();
        int t = 0;
        while (!halted && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // R9: feed one input word after an idle stall of gap cycles
    task automatic send(input logic [15:0] v, input int gap);
        logic [PC_W-1:0] a0;
        int t = 0;
        @(negedge clk);
        while (!in_ready && t < 5000) begin
            @(negedge clk);
            t++;
        end
        a0 = imem_addr;
        repeat (gap) @(negedge clk);
        if (gap > 0)
            chk(in_ready && imem_addr == a0, "R9 stall holds", int'(imem_addr), int'(a0));
        in_data  = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready, "R9 input accepted", in_ready, 0);
    endtask

    task automatic branch_block(input int op);
        int p = wp;
        emit(7, 16'd1);
        emit(op, 16'(p + 4));
        emit(0, 16'd0);
        emit(9, 16'(p + 5));
        emit(0, 16'd1);
        emit(17, 16'd0);
    endtask

    task automatic want_pair(input logic signed [15:0] a, input logic signed [15:0] b);
        want(16'(a + b), "R3 add");
        want(16'(a - b), "R3 sub");
        want(16'(a * b), "R3 mul");
        want((b == 0) ? 16'd0 : 16'(a / b), "R3 div / R4");
        want((b == 0) ? 16'd0 : 16'(a % b), "R3 rem / R4");
        want(16'(a == 0), "R6 beqz");
        want(16'(a != 0), "R6 bnez");
        want(16'(a >= 0), "R6 bgez");
        want(16'(a < 0),  "R6 bltz");
    endtask

    initial begin
        int vals [10] = '{0, 1, -1, 7, -7, 100, -300, 32767, -32767, 3};
        int k = 0;
        logic [PC_W-1:0] hold_pc;

        // Program 1: read two operands, print arithmetic and branch outcomes, loop
        clear_prog();
        emit(16, 16'd0); emit(8, 16'd1);
        emit(16, 16'd0); emit(8, 16'd2);
        for (int op = 2; op <= 6; op++) begin
            emit(7, 16'd1); emit(op, 16'd2); emit(17, 16'd0);
        end
        for (int op = 10; op <= 13; op++) branch_block(op);
        emit(9, 16'd0);

        do_reset();
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
                if (vals[j] == 0) continue;
                want_pair(16'(vals[i]), 16'(vals[j]));
                send(16'(vals[i]), k % 3);
                send(16'(vals[j]), (k + 1) % 4);
                k++;
            end
        end
        wait_drain();
        chk(!error, "R4 no error without zero divisor", error, 0);

        // R4: zero divisor yields 0, flags error, keeps running
        want_pair(16'sd5, 16'sd0);
        send(16'd5, 0);
        send(16'd0, 1);
        wait_drain();
        chk(error == 1'b1, "R4 error set", error, 1);
        repeat (10) @(negedge clk);
        chk(!halted && in_ready, "R4 execution continues", {halted, in_ready}, 1);

        // Program 2: immediates, indirect access, undefined opcode, nested calls, stop
        clear_prog();
        emit(0, 16'd100); emit(1, 16'hFFE2); emit(17, 0);          want(16'd70, "R2 addi negative");
        emit(0, 16'h7FFF); emit(1, 16'd1); emit(17, 0);             want(16'h8000, "R2 addi wrap");
        emit(0, 16'd10); emit(8, 16'd3); emit(0, 16'd1234); emit(20, 16'd3);
        emit(0, 16'd0); emit(7, 16'd10); emit(17, 0);               want(16'd1234, "R5 puti then get");
        emit(0, 16'd0); emit(19, 16'd3); emit(17, 0);               want(16'd1234, "R5 geti");
        emit(0, 16'd42); emit(8, 16'd10); emit(0, 16'd0); emit(19, 16'd3); emit(17, 0);
        want(16'd42, "R5 put then geti");
        emit(0, 16'd9); emit(8, 16'h0025); emit(0, 16'd0); emit(7, 16'd5); emit(17, 0);
        want(16'd9, "R5 address low bits");
        emit(0, 16'd55); emit(8'h40, 16'd0); emit(8'hFF, 16'd3); emit(17, 0);
        want(16'd55, "R12 undefined opcode");
        emit(14, 16'd200); emit(17, 0);                              want(16'd77, "R7 call return");
        emit(14, 16'd210); emit(17, 0);                              want(16'd78, "R7 nested call");
        emit(18, 16'd0);
        wp = 200; emit(0, 16'd77); emit(15, 0);
        wp = 210; emit(14, 16'd200); emit(1, 16'd1); emit(15, 0);

        do_reset();
        wait_halt();
        wait_drain();
        chk(halted && !error, "R11 stop halts cleanly", {halted, error}, 2);
        hold_pc = imem_addr;
        repeat (20) @(negedge clk);
        chk(halted && imem_addr == hold_pc, "R11 pc holds", int'(imem_addr), int'(hold_pc));

        // Program 3: unbounded recursion overflows the return stack (also R1 AC=0)
        clear_prog();
        emit(1, 16'd1); emit(17, 0); emit(14, 16'd0);
        for (int i = 1; i <= 9; i++) want(16'(i), "R8 overflow sequence / R1 ac zero");
        do_reset();
        wait_halt();
        wait_drain();
        chk(halted && error, "R8 overflow halts with error", {halted, error}, 3);
        chk(imem_addr == 2, "R8 pc at failing call", int'(imem_addr), 2);

        // Program 4: return with an empty stack
        clear_prog();
        emit(15, 0); emit(0, 16'd1); emit(17, 0);
        do_reset();
        wait_halt();
        repeat (10) @(negedge clk);
        chk(halted && error, "R8 underflow halts with error", {halted, error}, 3);
        chk(imem_addr == 0, "R8 pc at failing return", int'(imem_addr), 0);

        do_reset();
        chk(!error && !halted, "R1 reset clears error and halt", {error, halted}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=hung exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule